// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a stream of asynchronous serial characters on `rxd` into parallel words. The receive clock arrives as a one-cycle enable, `rxc_en`, in the system clock domain. Each pulse stands for one rising edge of the receive clock. A two-bit factor picks how many receive edges make up one bit time: one, sixteen or sixty-four. Code `00` parks the receiver. Word length (5 to 8 bits), parity (none, odd or even) and one or two stop bits are set by static configuration inputs. The block latches them at the start edge of each character.

In the oversampled modes the receiver finds the falling start edge and counts receive edges to the middle of the start bit. There it checks that the line is still low, and from then on it samples every bit at its centre. A character that completes raises `rx_ready` and updates the data and per-character error flags. A host read, signalled by `rd_ack`, drops `rx_ready` again. A line held low for two whole character frames is reported as a break until the line is seen high.

Top module: `rxo_async_rx`

## Requirements
- R1: With factor code `01`, the receive edge that first sees `rxd` low is the start sample. Each following receive edge samples the next bit.
- R2: With factor code `10`, the start bit is checked on the 9th receive edge, counting the edge that first saw `rxd` low as the first. Each later bit is sampled 16 edges after the previous one.
- R3: With factor code `11`, the start bit is checked on the 33rd receive edge, counting the detecting edge as the first. Later bits are sampled every 64 edges.
- R4: With factor code `00`, no character is ever started, whatever `rxd` does.
- R5: Data bits arrive LSB first. The word length is 5 + `cfg_wlen` bits (`00`=5 … `11`=8). Bits of `rx_data` above the word length read as zero.
- R6: When `cfg_par_en` is set, one parity bit follows the data. With `cfg_par_even`=1 the data and parity bits together hold an even count of ones; with 0, an odd count. A mismatch sets `parity_err` for that character; with parity off, `parity_err` is 0.
- R7: `framing_err` is set for a character whose stop sample is low. With `cfg_stop2`=1 both stop bits are sampled, and a low on either sets the flag.
- R8: A character starts only on a receive edge that finds `rxd` low while idle. A start bit that is high again at its centre sample is discarded: the receiver returns to idle and `rx_ready` does not change.
- R9: `rx_ready` is 0 after reset and rises in the cycle after a character completes. A cycle with `rd_ack` high clears it. If completion and `rd_ack` fall in the same cycle, `rx_ready` stays 1.
- R10: `overrun_err` is set for a character that completes while `rx_ready` is 1 and `rd_ack` is not high in that cycle. Otherwise it is 0 for that character.
- R11: `break_det` rises when two consecutive character frames complete with every sampled bit low, stop bits included. It clears on any receive edge that finds `rxd` high.
- R12: `rx_data`, `parity_err`, `framing_err` and `overrun_err` are 0 after reset and change only when a character completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxc_en | input | 1 | One-cycle pulse per rising edge of the receive clock |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_factor | input | 2 | Clock factor: 00 off, 01 x1, 10 x16, 11 x64 |
| cfg_wlen | input | 2 | Word length minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| rd_ack | input | 1 | Host has read the current character |
| rx_data | output | 8 | Last received character, upper bits zero |
| rx_ready | output | 1 | A character is waiting to be read |
| parity_err | output | 1 | Parity mismatch on the last character |
| framing_err | output | 1 | Low stop sample on the last character |
| overrun_err | output | 1 | Last character overwrote an unread one |
| break_det | output | 1 | Line held low for two frames |

## Verification
Character completion and a host read of the previous character can land on the same clock edge. In that case `rx_ready` must stay set and `overrun_err` must stay clear. The bench sets this up in the x1 mode, where the stop-bit receive edge is exactly the completion edge. It raises `rd_ack` in that same cycle on top of an unread character. It then compares the result with a second run that leaves out the read, which must report an overrun. The narrow-pulse frames, where each bit is valid only on its centre edge, fix the exact sample point in the x16 and x64 modes.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

   typedef enum logic [1:0] {
      FCT_OFF = 2'b00,
      FCT_X1  = 2'b01,
      FCT_X16 = 2'b10,
      FCT_X64 = 2'b11
   } factor_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP1,
      ST_STOP2
   } rx_state_e;

   typedef struct packed {
      factor_e    factor;
      logic [1:0] wlen;
      logic       par_en;
      logic       par_even;
      logic       stop2;
   } rx_cfg_t;

endpackage

// File: rtl/rxo_bit_timer.sv
// Down-counter of receive edges; fires a sample strobe when it reaches one.
module rxo_bit_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic             sample
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (run && tick) begin
         if (cnt == ONE) begin
            cnt <= period;
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end

   assign sample = run && tick && (cnt == ONE);

endmodule

// File: rtl/rxo_frame_fsm.sv
// Frame sequencer: start check, data capture, parity and stop sampling.
module rxo_frame_fsm
   import rxo_pkg::*;
#(
   parameter int MIN_DATA_W = 5,
   parameter int DATA_MAX   = 8,
   parameter int DIV_MID    = 16,
   parameter int DIV_HIGH   = 64,
   parameter int CNT_W      = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  rx_cfg_t             cfg,
   input  logic                sample,
   output logic                load,
   output logic [CNT_W-1:0]    load_val,
   output logic [CNT_W-1:0]    period,
   output logic                busy,
   output logic                done,
   output logic [DATA_MAX-1:0] data,
   output logic                perr,
   output logic                ferr,
   output logic                zero_frame
);

   localparam int               IDX_W  = $clog2(DATA_MAX);
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
   localparam logic [CNT_W-1:0] MID_P  = CNT_W'(DIV_MID);
   localparam logic [CNT_W-1:0] HIGH_P = CNT_W'(DIV_HIGH);
   localparam logic [CNT_W-1:0] MID_H  = CNT_W'(DIV_MID / 2);
   localparam logic [CNT_W-1:0] HIGH_H = CNT_W'(DIV_HIGH / 2);
   localparam logic [IDX_W-1:0] IDX_BASE = IDX_W'(MIN_DATA_W - 1);

   rx_state_e        state;
   rx_cfg_t          lat;
   logic [IDX_W-1:0] bit_idx;
   logic [IDX_W-1:0] last_idx;
   logic             par_acc;
   logic             par_bit;
   logic             stop_bad;
   logic             any_one;
   logic             start_det;

   assign start_det = (state == ST_IDLE) && tick && !rxd && (cfg.factor != FCT_OFF);
   assign load      = start_det;
   assign busy      = (state != ST_IDLE);
   assign last_idx  = IDX_BASE + IDX_W'(lat.wlen);

   // half a bit to the start centre, then a full bit per sample
   always_comb begin
      case (cfg.factor)
         FCT_X16: load_val = MID_H;
         FCT_X64: load_val = HIGH_H;
         default: load_val = ONE;
      endcase
      case (lat.factor)
         FCT_X16: period = MID_P;
         FCT_X64: period = HIGH_P;
         default: period = ONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         lat      <= '0;
         bit_idx  <= '0;
         par_acc  <= 1'b0;
         par_bit  <= 1'b0;
         stop_bad <= 1'b0;
         any_one  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_det) begin
                  lat      <= cfg;
                  bit_idx  <= '0;
                  par_acc  <= 1'b0;
                  par_bit  <= 1'b0;
                  stop_bad <= 1'b0;
                  any_one  <= 1'b0;
                  state    <= (cfg.factor == FCT_X1) ? ST_DATA : ST_START;
               end
            end
            ST_START: begin
               if (sample) begin
                  state <= rxd ? ST_IDLE : ST_DATA;
               end
            end
            ST_DATA: begin
               if (sample) begin
                  par_acc <= par_acc ^ rxd;
                  any_one <= any_one | rxd;
                  if (bit_idx == last_idx) begin
                     state <= lat.par_en ? ST_PAR : ST_STOP1;
                  end else begin
                     bit_idx <= bit_idx + IDX_W'(1);
                  end
               end
            end
            ST_PAR: begin
               if (sample) begin
                  par_bit <= rxd;
                  any_one <= any_one | rxd;
                  state   <= ST_STOP1;
               end
            end
            ST_STOP1: begin
               if (sample) begin
                  stop_bad <= !rxd;
                  any_one  <= any_one | rxd;
                  state    <= lat.stop2 ? ST_STOP2 : ST_IDLE;
               end
            end
            ST_STOP2: begin
               if (sample) begin
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // one capture flop per data position
   for (genvar i = 0; i < DATA_MAX; i++) begin : g_cap
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (start_det) begin
            bit_q <= 1'b0;
         end else if ((state == ST_DATA) && sample && (bit_idx == IDX_W'(i))) begin
            bit_q <= rxd;
         end
      end
      assign data[i] = bit_q;
   end

   assign done       = sample && (((state == ST_STOP1) && !lat.stop2) || (state == ST_STOP2));
   assign ferr       = !rxd || ((state == ST_STOP2) && stop_bad);
   assign zero_frame = !any_one && !rxd;
   assign perr       = lat.par_en && (par_acc ^ par_bit ^ !lat.par_even);

endmodule

// File: rtl/rxo_status_regs.sv
// Host-visible character register, flags and break tracking.
module rxo_status_regs #(
   parameter int DATA_MAX = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxd,
   input  logic                done,
   input  logic [DATA_MAX-1:0] data,
   input  logic                perr,
   input  logic                ferr,
   input  logic                zero_frame,
   input  logic                rd_ack,
   output logic [DATA_MAX-1:0] rx_data,
   output logic                rx_ready,
   output logic                parity_err,
   output logic                framing_err,
   output logic                overrun_err,
   output logic                break_det
);

   logic [1:0] zero_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ready <= 1'b0;
      end else if (done) begin
         rx_ready <= 1'b1;
      end else if (rd_ack) begin
         rx_ready <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         parity_err  <= 1'b0;
         framing_err <= 1'b0;
         overrun_err <= 1'b0;
      end else if (done) begin
         rx_data     <= data;
         parity_err  <= perr;
         framing_err <= ferr;
         overrun_err <= rx_ready && !rd_ack;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_run <= 2'd0;
      end else if (tick && rxd) begin
         zero_run <= 2'd0;
      end else if (done) begin
         if (!zero_frame) begin
            zero_run <= 2'd0;
         end else if (!zero_run[1]) begin
            zero_run <= zero_run + 2'd1;
         end
      end
   end

   assign break_det = zero_run[1];

endmodule

// File: rtl/rxo_async_rx.sv
module rxo_async_rx
   import rxo_pkg::*;
#(
   parameter int MIN_DATA_W = 5,
   parameter int DIV_MID    = 16,
   parameter int DIV_HIGH   = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rxc_en,
   input  logic                  rxd,
   input  logic [1:0]            cfg_factor,
   input  logic [1:0]            cfg_wlen,
   input  logic                  cfg_par_en,
   input  logic                  cfg_par_even,
   input  logic                  cfg_stop2,
   input  logic                  rd_ack,
   output logic [MIN_DATA_W+2:0] rx_data,
   output logic                  rx_ready,
   output logic                  parity_err,
   output logic                  framing_err,
   output logic                  overrun_err,
   output logic                  break_det
);

   localparam int DATA_MAX = MIN_DATA_W + 3;
   localparam int CNT_W    = $clog2(DIV_HIGH + 1);

   initial begin
      assert (MIN_DATA_W >= 1) else $error("MIN_DATA_W must be positive");
      assert ((DIV_MID >= 2) && (DIV_MID % 2 == 0)) else $error("DIV_MID must be even and >= 2");
      assert ((DIV_HIGH > DIV_MID) && (DIV_HIGH % 2 == 0)) else $error("DIV_HIGH must be even and above DIV_MID");
   end

   rx_cfg_t             cfg;
   logic                ld;
   logic [CNT_W-1:0]    ld_val;
   logic [CNT_W-1:0]    per;
   logic                busy;
   logic                smp;
   logic                frame_done;
   logic [DATA_MAX-1:0] frame_data;
   logic                frame_perr;
   logic                frame_ferr;
   logic                frame_zero;

   assign cfg = '{factor:   factor_e'(cfg_factor),
                  wlen:     cfg_wlen,
                  par_en:   cfg_par_en,
                  par_even: cfg_par_even,
                  stop2:    cfg_stop2};

   rxo_bit_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (rxc_en),
      .run      (busy),
      .load     (ld),
      .load_val (ld_val),
      .period   (per),
      .sample   (smp)
   );

   rxo_frame_fsm #(
      .MIN_DATA_W (MIN_DATA_W),
      .DATA_MAX   (DATA_MAX),
      .DIV_MID    (DIV_MID),
      .DIV_HIGH   (DIV_HIGH),
      .CNT_W      (CNT_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (rxc_en),
      .rxd        (rxd),
      .cfg        (cfg),
      .sample     (smp),
      .load       (ld),
      .load_val   (ld_val),
      .period     (per),
      .busy       (busy),
      .done       (frame_done),
      .data       (frame_data),
      .perr       (frame_perr),
      .ferr       (frame_ferr),
      .zero_frame (frame_zero)
   );

   rxo_status_regs #(
      .DATA_MAX (DATA_MAX)
   ) u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (rxc_en),
      .rxd         (rxd),
      .done        (frame_done),
      .data        (frame_data),
      .perr        (frame_perr),
      .ferr        (frame_ferr),
      .zero_frame  (frame_zero),
      .rd_ack      (rd_ack),
      .rx_data     (rx_data),
      .rx_ready    (rx_ready),
      .parity_err  (parity_err),
      .framing_err (framing_err),
      .overrun_err (overrun_err),
      .break_det   (break_det)
   );

endmodule

// File: rtl/rxo_async_rx_chk.sv
module rxo_async_rx_chk #(
   parameter int DATA_MAX = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rxc_en,
   input logic                rxd,
   input logic [1:0]          factor,
   input logic                rd_ack,
   input logic                busy,
   input logic                done,
   input logic [DATA_MAX-1:0] rx_data,
   input logic                rx_ready,
   input logic                parity_err,
   input logic                framing_err,
   input logic                overrun_err,
   input logic                break_det
);

   AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && factor == 2'b00) |=> !busy); // R4

   AST_START_NEEDS_LOW_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !(rxc_en && !rxd)) |=> !busy); // R8

   AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> rx_ready); // R9

   AST_ACK_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && rd_ack && !done) |=> !rx_ready); // R9

   AST_NO_FALSE_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rx_ready) |=> !overrun_err); // R10

   AST_BREAK_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (rxc_en && rxd) |=> !break_det); // R11

   AST_HOLD_BETWEEN_CHARS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> ($stable(rx_data) && $stable(parity_err) &&
                 $stable(framing_err) && $stable(overrun_err))); // R12

endmodule

bind rxo_async_rx rxo_async_rx_chk #(.DATA_MAX(MIN_DATA_W + 3)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rxc_en      (rxc_en),
   .rxd         (rxd),
   .factor      (cfg_factor),
   .rd_ack      (rd_ack),
   .busy        (busy),
   .done        (frame_done),
   .rx_data     (rx_data),
   .rx_ready    (rx_ready),
   .parity_err  (parity_err),
   .framing_err (framing_err),
   .overrun_err (overrun_err),
   .break_det   (break_det)
);

// File: tb/rxo_async_rx_tb.sv
`timescale 1ns/1ps
module rxo_async_rx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxc_en = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_factor = 2'b10;
   logic [1:0] cfg_wlen = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       cfg_stop2 = 1'b0;
   logic       rd_ack = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready;
   logic       parity_err;
   logic       framing_err;
   logic       overrun_err;
   logic       break_det;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   rxo_async_rx u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .rxc_en       (rxc_en),
      .rxd          (rxd),
      .cfg_factor   (cfg_factor),
      .cfg_wlen     (cfg_wlen),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_even (cfg_par_even),
      .cfg_stop2    (cfg_stop2),
      .rd_ack       (rd_ack),
      .rx_data      (rx_data),
      .rx_ready     (rx_ready),
      .parity_err   (parity_err),
      .framing_err  (framing_err),
      .overrun_err  (overrun_err),
      .break_det    (break_det)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         total++;
         bad++;
         $display("FAIL R9 watchdog actual=%0d expected<%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // {narrow, factor, wlen, par_en, par_even, stop2, bad_par, bad_stop, data}
   localparam int NV = 8;
   localparam logic [17:0] VECS [NV] = '{
      {1'b0, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5},
      {1'b1, 2'b10, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5B},
      {1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'hF3},
      {1'b0, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C},
      {1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h2E},
      {1'b1, 2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h81},
      {1'b0, 2'b10, 2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC7},
      {1'b0, 2'b11, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic v, input logic ack);
      @(negedge clk);
      rxd    = v;
      rxc_en = 1'b1;
      rd_ack = ack;
      @(negedge clk);
      rxc_en = 1'b0;
      rd_ack = 1'b0;
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   function automatic int fper(input logic [1:0] f);
      case (f)
         2'b01:   return 1;
         2'b11:   return 64;
         default: return 16;
      endcase
   endfunction

   // narrow: bit value is correct only on the centre receive edge
   task automatic send_bit(input logic v, input int f, input bit narrow,
                           input bit is_start, input bit ack_last);
      int c;
      c = (f == 1) ? 1 : (f / 2 + 1);
      for (int j = 1; j <= f; j++) begin
         logic d;
         d = v;
         if (narrow && j != c) d = ~v;
         if (is_start && j == 1) d = 1'b0;
         tick(d, ack_last && (j == f));
      end
   endtask

   task automatic send_frame(input logic [1:0] fct, input logic [1:0] wl, input logic pen,
                             input logic even, input logic two, input logic bpar,
                             input logic bstop, input logic [7:0] dat,
                             input bit narrow, input bit ack_last);
      int   f;
      int   len;
      logic p;
      logic sv;
      @(negedge clk);
      cfg_factor   = fct;
      cfg_wlen     = wl;
      cfg_par_en   = pen;
      cfg_par_even = even;
      cfg_stop2    = two;
      f   = fper(fct);
      len = 5 + int'(wl);
      p   = 1'b0;
      send_bit(1'b0, f, narrow, 1'b1, 1'b0);
      for (int i = 0; i < len; i++) begin
         p = p ^ dat[i];
         send_bit(dat[i], f, narrow, 1'b0, 1'b0);
      end
      if (pen) begin
         if (!even) p = ~p;
         send_bit(p ^ bpar, f, narrow, 1'b0, 1'b0);
      end
      sv = ~bstop;
      send_bit(sv, f, narrow, 1'b0, ack_last && !two);
      if (two) send_bit(sv, f, narrow, 1'b0, ack_last);
      for (int k = 0; k < 2 * f + 2; k++) tick(1'b1, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R9",  "ready after reset", 32'(rx_ready), 32'd0);
      chk("R12", "data after reset", 32'(rx_data), 32'd0);
      chk("R12", "errors after reset", {parity_err, framing_err, overrun_err}, 32'd0);
      chk("R11", "break after reset", 32'(break_det), 32'd0);

      // table walk
      for (int n = 0; n < NV; n++) begin
         logic [17:0] v;
         logic [7:0]  mask;
         string       fr;
         v    = VECS[n];
         mask = 8'((1 << (5 + int'(v[14:13]))) - 1);
         fr   = (v[16:15] == 2'b01) ? "R1" : (v[16:15] == 2'b10) ? "R2" : "R3";
         send_frame(v[16:15], v[14:13], v[12], v[11], v[10], v[9], v[8], v[7:0], v[17], 1'b0);
         chk("R9", "ready after frame", 32'(rx_ready), 32'd1);
         chk(fr, "data sampled at centre", 32'(rx_data), 32'(v[7:0] & mask));
         chk("R5", "upper bits zero", 32'(rx_data & ~mask), 32'd0);
         chk("R6", "parity flag", 32'(parity_err), 32'(v[12] & v[9]));
         chk("R7", "framing flag", 32'(framing_err), 32'(v[8]));
         chk("R10", "no overrun", 32'(overrun_err), 32'd0);
         ack_pulse();
         chk("R9", "ready cleared by read", 32'(rx_ready), 32'd0);
         chk("R12", "data held after read", 32'(rx_data), 32'(v[7:0] & mask));
      end

      // factor 00 never starts a character
      send_frame(2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0);
      chk("R4", "off mode no ready", 32'(rx_ready), 32'd0);
      chk("R4", "off mode data held", 32'(rx_data), 32'h3F);

      // false start: low for 8 edges, high on the 9th
      cfg_factor = 2'b10;
      cfg_wlen   = 2'b11;
      cfg_par_en = 1'b0;
      cfg_stop2  = 1'b0;
      for (int k = 0; k < 8; k++) tick(1'b0, 1'b0);
      for (int k = 0; k < 40; k++) tick(1'b1, 1'b0);
      chk("R8", "false start no ready", 32'(rx_ready), 32'd0);
      send_frame(2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h69, 1'b0, 1'b0);
      chk("R8", "receive after false start", 32'(rx_data), 32'h69);
      ack_pulse();

      // overrun without read
      send_frame(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
      send_frame(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0);
      chk("R10", "overrun flagged", 32'(overrun_err), 32'd1);
      chk("R10", "newest data kept", 32'(rx_data), 32'h22);

      // read lands on the completion edge
      send_frame(2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h33, 1'b0, 1'b1);
      chk("R9", "ready held when read meets completion", 32'(rx_ready), 32'd1);
      chk("R10", "no overrun when read meets completion", 32'(overrun_err), 32'd0);
      chk("R9", "data after coincident read", 32'(rx_data), 32'h33);
      ack_pulse();

      // break: x1, 5 data bits, no parity, one stop -> 7 edges per frame
      @(negedge clk);
      cfg_factor = 2'b01;
      cfg_wlen   = 2'b00;
      cfg_par_en = 1'b0;
      cfg_stop2  = 1'b0;
      for (int k = 0; k < 10; k++) tick(1'b0, 1'b0);
      chk("R11", "one zero frame is no break", 32'(break_det), 32'd0);
      for (int k = 0; k < 10; k++) tick(1'b0, 1'b0);
      chk("R11", "break after two zero frames", 32'(break_det), 32'd1);
      chk("R7", "zero frame framing", 32'(framing_err), 32'd1);
      chk("R5", "zero frame data", 32'(rx_data), 32'd0);
      tick(1'b1, 1'b0);
      chk("R11", "break cleared by high line", 32'(break_det), 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule